// File: doc/BRIEF.md
# Concurrent Partial-Reseeding LFSR Decompressor

This block expands compressed test data into scan vectors on chip. A Fibonacci LFSR of fixed polynomial feeds one scan chain from its lowest stage. One extra XOR sits in the feedback path. During the opening cycles of each scan window it folds a serial bit from the tester into the register. The LFSR state is therefore nudged rather than replaced, while the chain keeps filling. A full seed is written only at the start of each group of cubes. Within a group, every cube after the first is steered by a short burst of tester bits per window, and the register contents carry over from one cube to the next.

The chain length is rounded up to a whole number of windows, and the surplus bits fall off the far end of the chain. Once every window of a cube has been shifted, the block issues a capture pulse and then a done pulse. It then either starts the next cube or, at the end of a group, goes idle until the next seed arrives. If the tester has no valid bit in an injection cycle, shifting pauses for that cycle instead of using a stale bit.

Top module: `reseed_decomp`

## Requirements
- R1: A high `seed_load` takes priority over all other activity. It writes `seed_data` into the LFSR and restarts at the first window of the first cube of a group. In the next cycle `scan_out` equals `seed_data[0]`, and no shift happens in the load cycle itself.
- R2: `scan_out` is always LFSR bit 0. On each cycle with `scan_en` high the register moves one place toward bit 0. Its new top bit is the XOR of the state bits selected by the set bits of `TAPS`, XORed with the injected tester bit when injection is active.
- R3: The first cube after a seed runs fully autonomously: `tst_bit` and `tst_valid` have no effect on any of its scan bits.
- R4: In every later cube of a group, the first `INJ_N` shift cycles of each window XOR `tst_bit` into the feedback. The remaining `WIN_LEN-INJ_N` cycles of the window ignore the tester inputs.
- R5: The LFSR is not reloaded between cubes of a group, so each cube starts from the state the previous one left. A group consumes exactly `LFSR_W + INJ_N*WIN_CNT*(CUBES_PER_SEED-1)` tester bits, seed included.
- R6: In an injection cycle with `tst_valid` low, `scan_en` stays low, and the LFSR and `scan_out` hold.
- R7: A cube is `WIN_CNT*WIN_LEN` shifts, where `WIN_CNT = ceil(SCAN_LEN/WIN_LEN)`. `capture` pulses for one cycle right after the last shift, and `cube_done` pulses for one cycle right after `capture`. Neither cycle shifts.
- R8: After `cube_done`, the next cube's first shift cycle follows at once. After the `CUBES_PER_SEED`-th cube the block idles with `scan_en` low until `seed_load`.
- R9: During and after reset, before any seed, `scan_en`, `capture` and `cube_done` are low and `scan_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_load | input | 1 | Write a full seed and restart a group |
| seed_data | input | LFSR_W | Seed value |
| tst_valid | input | 1 | Tester bit present this cycle |
| tst_bit | input | 1 | Serial tester bit for feedback injection |
| scan_out | output | 1 | Scan chain data (LFSR bit 0) |
| scan_en | output | 1 | Chain shifts this cycle |
| capture | output | 1 | One-cycle capture pulse after a full cube |
| cube_done | output | 1 | One-cycle pulse after capture |

## Verification
Each scan bit is compared against an arithmetic model of the same register, across whole groups of three cubes of three padded windows each. Tester streams of all zeros, all ones, alternating bits and a scrambled pattern separate correct injection timing from wrong window offsets: an off-by-one injection or a skipped cube diverges at once under the scrambled stream but can hide under a constant one. Streams with gaps in `tst_valid` show that a stall holds state instead of consuming a bit. A reload in the middle of a cube shows that a seed restarts the group. The per-group bit and shift totals confirm that the state carries over and that the padded length is correct.

// File: rtl/reseed_pkg.sv
package reseed_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SHIFT = 2'd1,
      PH_CAPT  = 2'd2,
      PH_DONE  = 2'd3
   } phase_t;
endpackage

// File: rtl/reseed_lfsr.sv
module reseed_lfsr #(
   parameter int unsigned           WIDTH = 16,
   parameter logic [WIDTH-1:0]      TAPS  = 16'h002D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] seed,
   input  logic             step,
   input  logic             inj_bit,
   output logic [WIDTH-1:0] state
);
   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] tap_v;
   logic             fb;

   // select the tapped stages
   for (genvar i = 0; i < WIDTH; i++) begin : g_tap
      if (TAPS[i]) begin : g_on
         assign tap_v[i] = state_q[i];
      end else begin : g_off
         assign tap_v[i] = 1'b0;
      end
   end

   assign fb = (^tap_v) ^ inj_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= '0;
      else if (load)   state_q <= seed;
      else if (step)   state_q <= {fb, state_q[WIDTH-1:1]};
   end

   assign state = state_q;
endmodule

// File: rtl/reseed_seq.sv
module reseed_seq
   import reseed_pkg::*;
#(
   parameter int unsigned WIN_LEN = 8,
   parameter int unsigned INJ_N   = 3,
   parameter int unsigned WIN_CNT = 3,
   parameter int unsigned CUBES   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seed_load,
   input  logic tst_valid,
   output logic shift_en,
   output logic inj_en,
   output logic capture,
   output logic cube_done
);
   localparam int unsigned BIT_W = $clog2(WIN_LEN);
   localparam int unsigned WIN_W = (WIN_CNT > 1) ? $clog2(WIN_CNT) : 1;
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WIN_LEN - 1);
   localparam logic [BIT_W-1:0] BIT_INJ  = BIT_W'(INJ_N);
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CNT - 1);

   phase_t            phase_q;
   logic [BIT_W-1:0]  bit_q;
   logic [WIN_W-1:0]  win_q;
   logic              first_cube;
   logic              last_cube;

   assign inj_en    = (phase_q == PH_SHIFT) && !first_cube && (bit_q < BIT_INJ);
   assign shift_en  = !seed_load && (phase_q == PH_SHIFT) && (!inj_en || tst_valid);
   assign capture   = (phase_q == PH_CAPT);
   assign cube_done = (phase_q == PH_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bit_q   <= '0;
         win_q   <= '0;
      end else if (seed_load) begin
         phase_q <= PH_SHIFT;
         bit_q   <= '0;
         win_q   <= '0;
      end else begin
         case (phase_q)
            PH_SHIFT: if (shift_en) begin
               if (bit_q == BIT_LAST) begin
                  bit_q <= '0;
                  if (win_q == WIN_LAST) begin
                     win_q   <= '0;
                     phase_q <= PH_CAPT;
                  end else begin
                     win_q <= win_q + 1'b1;
                  end
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
            PH_CAPT: phase_q <= PH_DONE;
            PH_DONE: phase_q <= last_cube ? PH_IDLE : PH_SHIFT;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   // cube counter exists only when a group holds more than one cube
   if (CUBES > 1) begin : g_multi
      localparam int unsigned CUBE_W = $clog2(CUBES);
      localparam logic [CUBE_W-1:0] CUBE_LAST = CUBE_W'(CUBES - 1);
      logic [CUBE_W-1:0] cube_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  cube_q <= '0;
         else if (seed_load)          cube_q <= '0;
         else if (phase_q == PH_DONE) cube_q <= (cube_q == CUBE_LAST) ? '0 : cube_q + 1'b1;
      end
      assign first_cube = (cube_q == '0);
      assign last_cube  = (cube_q == CUBE_LAST);
   end else begin : g_static
      assign first_cube = 1'b1;
      assign last_cube  = 1'b1;
   end
endmodule

// File: rtl/reseed_decomp.sv
module reseed_decomp #(
   parameter int unsigned        LFSR_W         = 16,
   parameter logic [LFSR_W-1:0]  TAPS           = 16'h002D,
   parameter int unsigned        SCAN_LEN       = 20,
   parameter int unsigned        WIN_LEN        = 8,
   parameter int unsigned        INJ_N          = 3,
   parameter int unsigned        CUBES_PER_SEED = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_load,
   input  logic [LFSR_W-1:0] seed_data,
   input  logic              tst_valid,
   input  logic              tst_bit,
   output logic              scan_out,
   output logic              scan_en,
   output logic              capture,
   output logic              cube_done
);
   localparam int unsigned WIN_CNT   = (SCAN_LEN + WIN_LEN - 1) / WIN_LEN;
   localparam int unsigned SHIFT_CNT = WIN_CNT * WIN_LEN;

   if (LFSR_W < 2)            begin : g_chk_w   $error("LFSR_W must be at least 2"); end
   if (TAPS[0] == 1'b0)       begin : g_chk_tap $error("TAPS bit 0 must be set"); end
   if (INJ_N == 0)            begin : g_chk_n0  $error("INJ_N must be nonzero"); end
   if (INJ_N >= WIN_LEN)      begin : g_chk_n   $error("INJ_N must be below WIN_LEN"); end
   if (SCAN_LEN == 0)         begin : g_chk_len $error("SCAN_LEN must be nonzero"); end
   if (CUBES_PER_SEED == 0)   begin : g_chk_k   $error("CUBES_PER_SEED must be nonzero"); end

   logic              inj_en;
   logic              step;
   logic [LFSR_W-1:0] lfsr_state;

   reseed_seq #(
      .WIN_LEN (WIN_LEN),
      .INJ_N   (INJ_N),
      .WIN_CNT (WIN_CNT),
      .CUBES   (CUBES_PER_SEED)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .seed_load (seed_load),
      .tst_valid (tst_valid),
      .shift_en  (step),
      .inj_en    (inj_en),
      .capture   (capture),
      .cube_done (cube_done)
   );

   reseed_lfsr #(
      .WIDTH (LFSR_W),
      .TAPS  (TAPS)
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (seed_load),
      .seed    (seed_data),
      .step    (step),
      .inj_bit (inj_en & tst_bit),
      .state   (lfsr_state)
   );

   assign scan_out = lfsr_state[0];
   assign scan_en  = step;
endmodule

// File: rtl/reseed_decomp_chk.sv
module reseed_decomp_chk #(
   parameter int unsigned SHIFTS = 24,
   parameter int unsigned SW     = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          seed_load,
   input logic [SW-1:0] seed_data,
   input logic          scan_en,
   input logic          scan_out,
   input logic          capture,
   input logic          cube_done
);
   localparam int unsigned CW = $clog2(SHIFTS + 1);
   logic [CW-1:0] shifts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   shifts_q <= '0;
      else if (seed_load || capture) shifts_q <= '0;
      else if (scan_en)             shifts_q <= shifts_q + 1'b1;
   end

   a_r1_seed_lands: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> (scan_out == $past(seed_data[0])));

   a_r1_no_shift_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |-> !scan_en);

   a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_en && !seed_load) |=> $stable(scan_out));

   a_r7_full_cube: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> (shifts_q == CW'(SHIFTS)));

   a_r7_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !seed_load) |=> (!capture && cube_done));

   a_r7_quiet_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (capture || cube_done) |-> !scan_en);

   a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({capture, cube_done}) <= 1);
endmodule

bind reseed_decomp reseed_decomp_chk #(
   .SHIFTS (SHIFT_CNT),
   .SW     (LFSR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .seed_load (seed_load),
   .seed_data (seed_data),
   .scan_en   (scan_en),
   .scan_out  (scan_out),
   .capture   (capture),
   .cube_done (cube_done)
);

// File: tb/sim_reseed_decomp.sv
`timescale 1ns/1ps
module sim_reseed_decomp;
   localparam int R  = 16;
   localparam logic [R-1:0] TP = 16'h002D;
   localparam int SL = 20;
   localparam int WL = 8;
   localparam int NI = 3;
   localparam int K  = 3;
   localparam int WC = (SL + WL - 1) / WL;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic seed_load = 1'b0;
   logic [R-1:0] seed_data = '0;
   logic tst_valid = 1'b0;
   logic tst_bit = 1'b0;
   logic scan_out, scan_en, capture, cube_done;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int consumed = 0;
   int shifts = 0;
   bit finished = 1'b0;

   // reference model state
   int mst = 0;
   int mcube = 0, mwin = 0, mbit = 0;
   logic [R-1:0] mlf = '0;

   always #4 clk = ~clk;

   reseed_decomp #(
      .LFSR_W(R), .TAPS(TP), .SCAN_LEN(SL), .WIN_LEN(WL),
      .INJ_N(NI), .CUBES_PER_SEED(K)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_data(seed_data),
      .tst_valid(tst_valid), .tst_bit(tst_bit), .scan_out(scan_out),
      .scan_en(scan_en), .capture(capture), .cube_done(cube_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic pat_bit(input int pat, input int idx);
      case (pat)
         0: return 1'b0;
         1: return 1'b1;
         2: return idx[0];
         default: return logic'(((idx * 13) ^ (idx >> 2)) & 1);
      endcase
   endfunction

   task automatic step_cyc(input logic ld, input logic [R-1:0] sd, input logic v, input logic b);
      bit inj, en_e;
      logic fb;
      string tag;
      @(negedge clk);
      seed_load = ld; seed_data = sd; tst_valid = v; tst_bit = b;
      #1;
      cyc++;
      inj  = (mst == 1) && (mcube != 0) && (mbit < NI);
      en_e = !ld && (mst == 1) && (!inj || v);
      if (ld) tag = "R1";
      else if (inj && !v) tag = "R6";
      else if (mst == 0) tag = "R8";
      else tag = "R7";
      chk(scan_en == en_e, tag, scan_en, en_e);
      if (en_e) begin
         if (mcube == 0 && mwin == 0 && mbit == 0) tag = "R1";
         else if (mcube == 0) tag = "R3";
         else if (inj) tag = "R4";
         else if (mwin == 0 && mbit == NI) tag = "R5";
         else tag = "R2";
         chk(scan_out == mlf[0], tag, scan_out, mlf[0]);
         shifts++;
         if (inj) consumed++;
      end
      if (!en_e && !ld && mst != 1) chk(scan_out == mlf[0], "R6", scan_out, mlf[0]);
      chk(capture == (mst == 2), "R7", capture, mst == 2);
      chk(cube_done == (mst == 3), "R7", cube_done, mst == 3);
      if (ld) begin
         mlf = sd; mst = 1; mcube = 0; mwin = 0; mbit = 0;
      end else begin
         case (mst)
            1: if (en_e) begin
               fb = (^(mlf & TP)) ^ (inj & b);
               mlf = {fb, mlf[R-1:1]};
               if (mbit == WL - 1) begin
                  mbit = 0;
                  if (mwin == WC - 1) begin mwin = 0; mst = 2; end
                  else mwin++;
               end else mbit++;
            end
            2: mst = 3;
            3: if (mcube == K - 1) begin mcube = 0; mst = 0; end
               else begin mcube++; mst = 1; end
            default: ;
         endcase
      end
   endtask

   task automatic run_group(input logic [R-1:0] sd, input int pat, input bit stall);
      int guard = 0;
      consumed = 0; shifts = 0;
      step_cyc(1'b1, sd, 1'b1, 1'b0);
      while (mst != 0 && guard < 1000) begin
         step_cyc(1'b0, '0, stall ? logic'((cyc % 4) != 1) : 1'b1, pat_bit(pat, cyc));
         guard++;
      end
      chk(consumed == R - R + NI * WC * (K - 1), "R5", consumed, NI * WC * (K - 1));
      chk(consumed + R == R + NI * WC * (K - 1), "R5", consumed + R, R + NI * WC * (K - 1));
      chk(shifts == K * WC * WL, "R7", shifts, K * WC * WL);
      // idle after the group: tester activity must not start shifting
      for (int i = 0; i < 6; i++) step_cyc(1'b0, '0, 1'b1, 1'b1);
      chk(mst == 0, "R8", mst, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(scan_en == 1'b0, "R9", scan_en, 0);
      chk(capture == 1'b0, "R9", capture, 0);
      chk(cube_done == 1'b0, "R9", cube_done, 0);
      chk(scan_out == 1'b0, "R9", scan_out, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) step_cyc(1'b0, '0, 1'b1, 1'b1);
      chk(scan_out == 1'b0, "R9", scan_out, 0);

      run_group(16'hACE1, 0, 1'b0);
      run_group(16'h1234, 1, 1'b0);
      run_group(16'hBEEF, 2, 1'b1);
      run_group(16'h0001, 3, 1'b0);
      run_group(16'h8F3B, 3, 1'b1);

      // reload in the middle of the second cube restarts the group
      step_cyc(1'b1, 16'h5A5A, 1'b1, 1'b0);
      for (int i = 0; i < 40; i++) step_cyc(1'b0, '0, 1'b1, pat_bit(3, cyc));
      chk(mcube == 1, "R1", mcube, 1);
      run_group(16'h7777, 3, 1'b1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule